// File: doc/BRIEF.md
# MOESI L1 Line Coherence Controller

This block is the state machine behind a single line of a private L1 cache in a directory-based MOESI protocol. Data storage, the network and address decoding are handled elsewhere. Each cycle the surrounding logic may present one decoded event: a processor access, a request forwarded by the directory, a response, a writeback verdict, an internal all-acks trigger or the end of a lockout timer. In the same cycle the controller decides whether that event is consumed (pop), sent back to the tail of its queue (recycle) or rejected as illegal. It raises at most one message strobe and computes the line's next state. That state is registered on the following clock edge.

Two kinds of state set this controller apart. The first is a pair of lockout states, entered after the line gains write ownership. While a lockout state is held, every forwarded request and every replacement is deferred, so the processor is sure to get at least one use of the line. The second is a group of transient states, in which processor traffic that cannot make progress is recycled instead of being stalled in place. An event that has no meaning in the current state sets a sticky error flag and changes nothing else.

Top module: `moesi_l1_line_ctrl`

## Requirements
- R1: After reset the 4-bit state_o is 0 (invalid) and err_o is low. The state codes are: 0 invalid, 1 shared, 2 owned, 3 clean exclusive, 4 clean exclusive locked, 5 dirty, 6 dirty locked, 7 invalid-to-exclusive, 8 shared-to-exclusive, 9 owned-to-exclusive, 10 invalid-to-shared, 11 shared-evicting, 12 owned-evicting, 13 exclusive-evicting, 14 evict-lost.
- R2: An event is presented on the 5-bit evt_i together with evt_valid_i. The event codes are: 0 load, 1 ifetch, 2 store, 3 replacement, 4 own GETX, 5 forwarded GETX, 6 forwarded GETS, 7 forwarded DMA read, 8 invalidate, 9 ack, 10 data, 11 exclusive data, 12 writeback ack, 13 writeback ack with data, 14 writeback nack, 15 all acks, 16 use timeout. While evt_valid_i is low, every strobe stays low and the state holds.
- R3: A load or an ifetch pops with no message in shared, owned, clean exclusive, dirty, both locked states, shared-to-exclusive and owned-to-exclusive, and the state does not change. In invalid, the same access sends GETS and moves to invalid-to-shared.
- R4: A store or a replacement is recycled in every transient state. A load or an ifetch is recycled in invalid-to-exclusive, invalid-to-shared and in the three evicting states and evict-lost. A recycle leaves the state unchanged.
- R5: In either locked state, forwarded GETX, forwarded GETS, forwarded DMA read, own GETX, invalidate and replacement are all recycled.
- R6: A store sends GETX and moves to the matching pending state from invalid, shared and owned (7, 8 and 9). Clean exclusive and dirty go to dirty with no message. Both locked states go to dirty locked.
- R7: A forwarded GETS sends shared data in owned and clean exclusive, moving to owned. In dirty it sends exclusive data and moves to invalid. A forwarded GETX sends exclusive data from owned, clean exclusive or dirty and moves to invalid. From owned-to-exclusive it moves to invalid-to-exclusive, and from the owned- or exclusive-evicting state it moves to evict-lost. A forwarded DMA read sends a DMA response without a state change in any state that holds ownership.
- R8: In invalid-to-shared, data moves to shared with an unblock. Exclusive data moves to clean exclusive locked with an exclusive unblock and starts the use timer. All-acks in owned-to-exclusive moves to dirty locked with an exclusive unblock and starts the timer. Data or exclusive data in invalid-to-exclusive or shared-to-exclusive moves to owned-to-exclusive.
- R9: A replacement sends PUTS from shared (to 11), PUTO from owned (to 12) and PUTX from clean exclusive or dirty (to 13). In invalid it pops with no message.
- R10: A writeback ack with data in any evicting state sends writeback data and ends in invalid. A nack in owned- or exclusive-evicting moves to owned-evicting. A nack in evict-lost ends in invalid. A plain writeback ack ends any evicting state, and evict-lost, in invalid.
- R11: A use timeout returns each locked state to its unlocked state. An invalidate sends an ack: shared goes to invalid, shared-to-exclusive goes to invalid-to-exclusive, and shared-evicting goes to evict-lost.
- R12: An event that is undefined in the current state, including codes 17 to 31, leaves the state unchanged and produces no strobe, pop or recycle. It sets err_o from the next cycle, and err_o stays high until reset.
- R13: msg_o carries at most one set bit, and pop_o and recycle_o are never high together. The msg_o bit positions are: 0 GETS, 1 GETX, 2 PUTX, 3 PUTO, 4 PUTS, 5 shared data, 6 exclusive data, 7 invalidate ack, 8 unblock, 9 exclusive unblock, 10 DMA response, 11 writeback data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | 1 | An event is presented this cycle |
| evt_i | input | 5 | Event code |
| state_o | output | 4 | Registered line state |
| msg_o | output | 12 | One-hot message send strobes |
| pop_o | output | 1 | Event consumed from its queue |
| recycle_o | output | 1 | Event returned to the tail of its queue |
| timer_set_o | output | 1 | Start the use lockout timer |
| err_o | output | 1 | Sticky illegal-event flag |

## Verification
A single accepted event can fire a message strobe, start the timer and change the state, all in the same cycle. The sweep therefore drives every event code against every reachable state and checks the message, the pop or recycle, the timer strobe, the next state and the error flag together. The sticky error flag can also coincide with a later legal transition. To provoke this, the bench presents an illegal ack in invalid and then a load. It then judges that the load still sends GETS and advances the state while err_o stays high.

// File: rtl/moesi_l1_pkg.sv
package moesi_l1_pkg;

  localparam int ST_W  = 4;
  localparam int EV_W  = 5;
  localparam int MSG_W = 12;

  typedef enum logic [ST_W-1:0] {
    ST_INV    = 4'd0,
    ST_SHD    = 4'd1,
    ST_OWN    = 4'd2,
    ST_EXC    = 4'd3,
    ST_EXC_LK = 4'd4,
    ST_DRT    = 4'd5,
    ST_DRT_LK = 4'd6,
    ST_I2X    = 4'd7,
    ST_S2X    = 4'd8,
    ST_O2X    = 4'd9,
    ST_I2S    = 4'd10,
    ST_S2I    = 4'd11,
    ST_O2I    = 4'd12,
    ST_X2I    = 4'd13,
    ST_Z2I    = 4'd14
  } line_st_e;

  typedef enum logic [EV_W-1:0] {
    EV_LOAD     = 5'd0,
    EV_IFETCH   = 5'd1,
    EV_STORE    = 5'd2,
    EV_REPL     = 5'd3,
    EV_OWN_GETX = 5'd4,
    EV_FWD_GETX = 5'd5,
    EV_FWD_GETS = 5'd6,
    EV_FWD_DMA  = 5'd7,
    EV_INV      = 5'd8,
    EV_ACK      = 5'd9,
    EV_DATA     = 5'd10,
    EV_DATA_X   = 5'd11,
    EV_WB_ACK   = 5'd12,
    EV_WB_ACK_D = 5'd13,
    EV_WB_NACK  = 5'd14,
    EV_ALL_ACKS = 5'd15,
    EV_USE_TO   = 5'd16
  } line_ev_e;

  localparam logic [MSG_W-1:0] M_NONE    = '0;
  localparam logic [MSG_W-1:0] M_GETS    = MSG_W'(1) << 0;
  localparam logic [MSG_W-1:0] M_GETX    = MSG_W'(1) << 1;
  localparam logic [MSG_W-1:0] M_PUTX    = MSG_W'(1) << 2;
  localparam logic [MSG_W-1:0] M_PUTO    = MSG_W'(1) << 3;
  localparam logic [MSG_W-1:0] M_PUTS    = MSG_W'(1) << 4;
  localparam logic [MSG_W-1:0] M_DATA    = MSG_W'(1) << 5;
  localparam logic [MSG_W-1:0] M_DATA_X  = MSG_W'(1) << 6;
  localparam logic [MSG_W-1:0] M_INV_ACK = MSG_W'(1) << 7;
  localparam logic [MSG_W-1:0] M_UNBLK   = MSG_W'(1) << 8;
  localparam logic [MSG_W-1:0] M_UNBLK_X = MSG_W'(1) << 9;
  localparam logic [MSG_W-1:0] M_DMA     = MSG_W'(1) << 10;
  localparam logic [MSG_W-1:0] M_WB_DATA = MSG_W'(1) << 11;

  typedef struct packed {
    logic             legal;
    line_st_e         nxt;
    logic [MSG_W-1:0] msg;
    logic             pop;
    logic             rec;
    logic             tmr;
  } line_act_t;

  function automatic line_act_t act_go(line_st_e n, logic [MSG_W-1:0] m);
    line_act_t a;
    a       = '0;
    a.legal = 1'b1;
    a.nxt   = n;
    a.msg   = m;
    a.pop   = 1'b1;
    return a;
  endfunction

  function automatic line_act_t act_rec(line_st_e s);
    line_act_t a;
    a       = '0;
    a.legal = 1'b1;
    a.nxt   = s;
    a.rec   = 1'b1;
    return a;
  endfunction

  function automatic line_act_t act_bad(line_st_e s);
    line_act_t a;
    a     = '0;
    a.nxt = s;
    return a;
  endfunction

endpackage

// File: rtl/moesi_l1_proc_tbl.sv
module moesi_l1_proc_tbl
  import moesi_l1_pkg::*;
(
  input  line_st_e         st_i,
  input  logic [EV_W-1:0]  ev_i,
  output line_act_t        act_o
);

  logic is_rd;

  always_comb begin
    is_rd = (ev_i == EV_LOAD) || (ev_i == EV_IFETCH);
    act_o = act_bad(st_i);
    case (st_i)
      ST_INV: begin
        if (is_rd)                act_o = act_go(ST_I2S, M_GETS);
        else if (ev_i == EV_STORE) act_o = act_go(ST_I2X, M_GETX);
        else if (ev_i == EV_REPL)  act_o = act_go(ST_INV, M_NONE);
      end
      ST_SHD: begin
        if (is_rd)                act_o = act_go(ST_SHD, M_NONE);
        else if (ev_i == EV_STORE) act_o = act_go(ST_S2X, M_GETX);
        else if (ev_i == EV_REPL)  act_o = act_go(ST_S2I, M_PUTS);
      end
      ST_OWN: begin
        if (is_rd)                act_o = act_go(ST_OWN, M_NONE);
        else if (ev_i == EV_STORE) act_o = act_go(ST_O2X, M_GETX);
        else if (ev_i == EV_REPL)  act_o = act_go(ST_O2I, M_PUTO);
      end
      ST_EXC, ST_DRT: begin
        if (is_rd)                act_o = act_go(st_i, M_NONE);
        else if (ev_i == EV_STORE) act_o = act_go(ST_DRT, M_NONE);
        else if (ev_i == EV_REPL)  act_o = act_go(ST_X2I, M_PUTX);
      end
      ST_EXC_LK, ST_DRT_LK: begin
        // lockout: reads and writes proceed, eviction waits
        if (is_rd)                act_o = act_go(st_i, M_NONE);
        else if (ev_i == EV_STORE) act_o = act_go(ST_DRT_LK, M_NONE);
        else if (ev_i == EV_REPL)  act_o = act_rec(st_i);
      end
      ST_S2X, ST_O2X: begin
        if (is_rd)                act_o = act_go(st_i, M_NONE);
        else if (ev_i == EV_STORE || ev_i == EV_REPL) act_o = act_rec(st_i);
      end
      ST_I2X, ST_I2S, ST_S2I, ST_O2I, ST_X2I, ST_Z2I: begin
        if (is_rd || ev_i == EV_STORE || ev_i == EV_REPL) act_o = act_rec(st_i);
      end
      default: act_o = act_bad(st_i);
    endcase
  end

endmodule

// File: rtl/moesi_l1_req_tbl.sv
module moesi_l1_req_tbl
  import moesi_l1_pkg::*;
(
  input  line_st_e         st_i,
  input  logic [EV_W-1:0]  ev_i,
  output line_act_t        act_o
);

  logic fwd;

  always_comb begin
    fwd   = (ev_i >= EV_OWN_GETX) && (ev_i <= EV_INV);
    act_o = act_bad(st_i);
    if ((st_i == ST_EXC_LK || st_i == ST_DRT_LK) && fwd) begin
      act_o = act_rec(st_i);
    end else begin
      case (st_i)
        ST_INV, ST_SHD: begin
          if (ev_i == EV_INV) act_o = act_go(ST_INV, M_INV_ACK);
        end
        ST_OWN, ST_EXC: begin
          case (ev_i)
            EV_FWD_GETS: act_o = act_go(ST_OWN, M_DATA);
            EV_FWD_GETX: act_o = act_go(ST_INV, M_DATA_X);
            EV_FWD_DMA:  act_o = act_go(st_i, M_DMA);
            default:     act_o = act_bad(st_i);
          endcase
        end
        ST_DRT: begin
          case (ev_i)
            EV_FWD_GETS: act_o = act_go(ST_INV, M_DATA_X);
            EV_FWD_GETX: act_o = act_go(ST_INV, M_DATA_X);
            EV_FWD_DMA:  act_o = act_go(ST_DRT, M_DMA);
            default:     act_o = act_bad(st_i);
          endcase
        end
        ST_I2X, ST_S2X: begin
          if (ev_i == EV_INV) act_o = act_go(ST_I2X, M_INV_ACK);
        end
        ST_I2S: begin
          if (ev_i == EV_INV) act_o = act_go(ST_I2S, M_INV_ACK);
        end
        ST_O2X: begin
          case (ev_i)
            EV_OWN_GETX: act_o = act_go(ST_O2X, M_NONE);
            EV_FWD_GETS: act_o = act_go(ST_O2X, M_DATA);
            EV_FWD_GETX: act_o = act_go(ST_I2X, M_DATA_X);
            EV_FWD_DMA:  act_o = act_go(ST_O2X, M_DMA);
            default:     act_o = act_bad(st_i);
          endcase
        end
        ST_S2I: begin
          case (ev_i)
            EV_INV:      act_o = act_go(ST_Z2I, M_INV_ACK);
            EV_WB_ACK:   act_o = act_go(ST_INV, M_NONE);
            EV_WB_ACK_D: act_o = act_go(ST_INV, M_WB_DATA);
            default:     act_o = act_bad(st_i);
          endcase
        end
        ST_O2I, ST_X2I: begin
          case (ev_i)
            EV_FWD_GETS: act_o = act_go(ST_O2I, M_DATA);
            EV_FWD_GETX: act_o = act_go(ST_Z2I, M_DATA_X);
            EV_FWD_DMA:  act_o = act_go(st_i, M_DMA);
            EV_WB_ACK:   act_o = act_go(ST_INV, M_NONE);
            EV_WB_ACK_D: act_o = act_go(ST_INV, M_WB_DATA);
            EV_WB_NACK:  act_o = act_go(ST_O2I, M_NONE);
            default:     act_o = act_bad(st_i);
          endcase
        end
        ST_Z2I: begin
          case (ev_i)
            EV_INV:     act_o = act_go(ST_Z2I, M_INV_ACK);
            EV_WB_ACK:  act_o = act_go(ST_INV, M_NONE);
            EV_WB_NACK: act_o = act_go(ST_INV, M_NONE);
            default:    act_o = act_bad(st_i);
          endcase
        end
        default: act_o = act_bad(st_i);
      endcase
    end
  end

endmodule

// File: rtl/moesi_l1_rsp_tbl.sv
module moesi_l1_rsp_tbl
  import moesi_l1_pkg::*;
(
  input  line_st_e         st_i,
  input  logic [EV_W-1:0]  ev_i,
  output line_act_t        act_o
);

  always_comb begin
    act_o = act_bad(st_i);
    case (st_i)
      ST_I2X, ST_S2X: begin
        case (ev_i)
          EV_ACK:            act_o = act_go(st_i, M_NONE);
          EV_DATA, EV_DATA_X: act_o = act_go(ST_O2X, M_NONE);
          default:           act_o = act_bad(st_i);
        endcase
      end
      ST_O2X: begin
        case (ev_i)
          EV_ACK:      act_o = act_go(ST_O2X, M_NONE);
          EV_ALL_ACKS: begin
            act_o     = act_go(ST_DRT_LK, M_UNBLK_X);
            act_o.tmr = 1'b1;
          end
          default:     act_o = act_bad(st_i);
        endcase
      end
      ST_I2S: begin
        case (ev_i)
          EV_DATA:   act_o = act_go(ST_SHD, M_UNBLK);
          EV_DATA_X: begin
            act_o     = act_go(ST_EXC_LK, M_UNBLK_X);
            act_o.tmr = 1'b1;
          end
          default:   act_o = act_bad(st_i);
        endcase
      end
      ST_EXC_LK: if (ev_i == EV_USE_TO) act_o = act_go(ST_EXC, M_NONE);
      ST_DRT_LK: if (ev_i == EV_USE_TO) act_o = act_go(ST_DRT, M_NONE);
      default:   act_o = act_bad(st_i);
    endcase
  end

endmodule

// File: rtl/moesi_l1_line_ctrl.sv
module moesi_l1_line_ctrl
  import moesi_l1_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  logic [EV_W-1:0]  evt_i,
  output logic [ST_W-1:0]  state_o,
  output logic [MSG_W-1:0] msg_o,
  output logic             pop_o,
  output logic             recycle_o,
  output logic             timer_set_o,
  output logic             err_o
);

  line_st_e  state_q, state_d;
  logic      err_q;
  line_act_t act_proc, act_req, act_rsp, act;
  logic      is_proc, is_req, is_rsp, take;

  moesi_l1_proc_tbl i_proc (.st_i(state_q), .ev_i(evt_i), .act_o(act_proc));
  moesi_l1_req_tbl  i_req  (.st_i(state_q), .ev_i(evt_i), .act_o(act_req));
  moesi_l1_rsp_tbl  i_rsp  (.st_i(state_q), .ev_i(evt_i), .act_o(act_rsp));

  always_comb begin
    is_proc = evt_i <= EV_REPL;
    is_req  = ((evt_i >= EV_OWN_GETX) && (evt_i <= EV_INV)) ||
              ((evt_i >= EV_WB_ACK) && (evt_i <= EV_WB_NACK));
    is_rsp  = ((evt_i >= EV_ACK) && (evt_i <= EV_DATA_X)) ||
              (evt_i == EV_ALL_ACKS) || (evt_i == EV_USE_TO);
    if (is_proc)     act = act_proc;
    else if (is_req) act = act_req;
    else if (is_rsp) act = act_rsp;
    else             act = act_bad(state_q);
    take    = evt_valid_i && act.legal;
    state_d = take ? act.nxt : state_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INV;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_q | (evt_valid_i & ~act.legal);
    end
  end

  assign state_o     = state_q;
  assign err_o       = err_q;
  assign msg_o       = take ? act.msg : M_NONE;
  assign pop_o       = take & act.pop;
  assign recycle_o   = take & act.rec;
  assign timer_set_o = take & act.tmr;

  AST_ONE_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(msg_o)); // R13
  AST_POP_XOR_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_o && recycle_o)); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |-> (msg_o == '0) && !pop_o && !recycle_o && !timer_set_o); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |=> $stable(state_o)); // R2
  AST_REC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recycle_o |=> $stable(state_o)); // R4
  AST_LOCK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_set_o |=> (state_o == ST_EXC_LK) || (state_o == ST_DRT_LK)); // R8
  AST_ILLEGAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !pop_o && !recycle_o) |=> $stable(state_o) && err_o); // R12
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R12

endmodule

// File: tb/test_moesi_l1_line_ctrl.sv
`timescale 1ns/1ps
module test_moesi_l1_line_ctrl;

  localparam int S_INV = 0, S_SHD = 1, S_OWN = 2, S_EXC = 3, S_EXC_LK = 4,
                 S_DRT = 5, S_DRT_LK = 6, S_I2X = 7, S_S2X = 8, S_O2X = 9,
                 S_I2S = 10, S_S2I = 11, S_O2I = 12, S_X2I = 13, S_Z2I = 14;
  localparam int NST = 15;
  localparam int NEV = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [4:0]  evt = '0;
  logic [3:0]  state;
  logic [11:0] msg;
  logic        pop, rec, tmr, err;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  moesi_l1_line_ctrl i_moesi_l1_line_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(vld), .evt_i(evt),
    .state_o(state), .msg_o(msg), .pop_o(pop), .recycle_o(rec),
    .timer_set_o(tmr), .err_o(err));

  // packed expectation: [20] legal [19] pop [18] rec [17] tmr [11:8] next [3:0] msg bit+1
  function automatic int go(int nx, int mb);
    return (1 << 20) | (1 << 19) | (nx << 8) | (mb + 1);
  endfunction
  function automatic int rc(int s);
    return (1 << 20) | (1 << 18) | (s << 8);
  endfunction

  function automatic int model(int s, int e);
    bit lk   = (s == S_EXC_LK) || (s == S_DRT_LK);
    bit busy = (s == S_I2X) || (s == S_I2S) || (s >= S_S2I);
    int bad  = s << 8;
    case (e)
      0, 1: begin
        if (busy) return rc(s);
        if (s == S_INV) return go(S_I2S, 0);
        return go(s, -1);
      end
      2: case (s)
        S_INV: return go(S_I2X, 1);
        S_SHD: return go(S_S2X, 1);
        S_OWN: return go(S_O2X, 1);
        S_EXC, S_DRT: return go(S_DRT, -1);
        S_EXC_LK, S_DRT_LK: return go(S_DRT_LK, -1);
        default: return rc(s);
      endcase
      3: case (s)
        S_INV: return go(S_INV, -1);
        S_SHD: return go(S_S2I, 4);
        S_OWN: return go(S_O2I, 3);
        S_EXC, S_DRT: return go(S_X2I, 2);
        default: return rc(s);
      endcase
      default: ;
    endcase
    if (lk && e >= 4 && e <= 8) return rc(s);
    case (e)
      4: return (s == S_O2X) ? go(S_O2X, -1) : bad;
      5: case (s)
        S_OWN, S_EXC, S_DRT: return go(S_INV, 6);
        S_O2X: return go(S_I2X, 6);
        S_O2I, S_X2I: return go(S_Z2I, 6);
        default: return bad;
      endcase
      6: case (s)
        S_OWN, S_EXC: return go(S_OWN, 5);
        S_DRT: return go(S_INV, 6);
        S_O2X: return go(S_O2X, 5);
        S_O2I, S_X2I: return go(S_O2I, 5);
        default: return bad;
      endcase
      7: case (s)
        S_OWN, S_EXC, S_DRT, S_O2X, S_O2I, S_X2I: return go(s, 10);
        default: return bad;
      endcase
      8: case (s)
        S_INV, S_SHD: return go(S_INV, 7);
        S_I2X, S_S2X: return go(S_I2X, 7);
        S_I2S: return go(S_I2S, 7);
        S_S2I, S_Z2I: return go(S_Z2I, 7);
        default: return bad;
      endcase
      9:  return (s == S_I2X || s == S_S2X || s == S_O2X) ? go(s, -1) : bad;
      10: if (s == S_I2X || s == S_S2X) return go(S_O2X, -1);
          else return (s == S_I2S) ? go(S_SHD, 8) : bad;
      11: if (s == S_I2X || s == S_S2X) return go(S_O2X, -1);
          else return (s == S_I2S) ? (go(S_EXC_LK, 9) | (1 << 17)) : bad;
      12: return (s >= S_S2I) ? go(S_INV, -1) : bad;
      13: return (s >= S_S2I && s <= S_X2I) ? go(S_INV, 11) : bad;
      14: if (s == S_O2I || s == S_X2I) return go(S_O2I, -1);
          else return (s == S_Z2I) ? go(S_INV, -1) : bad;
      15: return (s == S_O2X) ? (go(S_DRT_LK, 9) | (1 << 17)) : bad;
      16: if (s == S_EXC_LK) return go(S_EXC, -1);
          else return (s == S_DRT_LK) ? go(S_DRT, -1) : bad;
      default: return bad;
    endcase
  endfunction

  function automatic string tag(int s, int e);
    if (((model(s, e) >> 20) & 1) == 0) return "R12";
    if ((s == S_EXC_LK || s == S_DRT_LK) && e >= 3 && e <= 8) return "R5";
    if (((model(s, e) >> 18) & 1) == 1) return "R4";
    case (e)
      0, 1: return "R3";
      2: return "R6";
      3: return "R9";
      4, 5, 6, 7: return "R7";
      8, 16: return "R11";
      9, 10, 11, 15: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    vld   = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic step(int e);
    vld = 1'b1;
    evt = 5'(e);
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic go_to(int s);
    case (s)
      S_SHD:    begin step(0); step(10); end
      S_OWN:    begin step(0); step(11); step(16); step(6); end
      S_EXC:    begin step(0); step(11); step(16); end
      S_EXC_LK: begin step(0); step(11); end
      S_DRT:    begin step(0); step(11); step(16); step(2); end
      S_DRT_LK: begin step(2); step(10); step(15); end
      S_I2X:    step(2);
      S_S2X:    begin step(0); step(10); step(2); end
      S_O2X:    begin step(2); step(10); end
      S_I2S:    step(0);
      S_S2I:    begin step(0); step(10); step(3); end
      S_O2I:    begin step(0); step(11); step(16); step(6); step(3); end
      S_X2I:    begin step(0); step(11); step(16); step(3); end
      S_Z2I:    begin step(0); step(10); step(3); step(8); end
      default:  ;
    endcase
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check(state == 4'd0 && !err && msg == '0 && !pop && !rec && !tmr,
          "R1", "reset", {err, state}, 0);

    // R2 idle cycles with a store on the bus but valid low
    go_to(S_SHD);
    evt = 5'd2;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(msg == '0 && !pop && !rec && !tmr, "R2", "idle strobes", {pop, rec, msg}, 0);
      @(negedge clk);
      check(state == 4'(S_SHD), "R2", "idle hold", state, S_SHD);
    end

    // R12 sticky error coinciding with a later legal transition
    do_reset();
    step(9);
    check(err && state == 4'(S_INV), "R12", "illegal ack", {err, state}, 'h10);
    vld = 1'b1; evt = 5'd0; #1;
    check(msg == 12'h001 && pop, "R12", "load after error", msg, 1);
    @(negedge clk); vld = 1'b0;
    check(err && state == 4'(S_I2S), "R12", "sticky err", {err, state}, 'h1a);
    step(10);
    check(err && state == 4'(S_SHD), "R12", "sticky err kept", {err, state}, 'h11);

    // R3..R13 exhaustive state x event sweep
    for (int s = 0; s < NST; s++) begin
      for (int e = 0; e <= NEV; e++) begin
        int ev = (e == NEV) ? 31 : e;
        int x;
        logic [11:0] emsg;
        do_reset();
        go_to(s);
        check(state == 4'(s) && !err, "R1", "path to state", state, s);
        x    = model(s, ev);
        emsg = ((x & 'hf) == 0) ? 12'h000 : (12'h001 << ((x & 'hf) - 1));
        vld = 1'b1; evt = 5'(ev); #1;
        check(msg == emsg && pop == x[19] && rec == x[18] && tmr == x[17] &&
              $countones(msg) <= 1 && !(pop && rec),
              tag(s, ev), $sformatf("strobes s%0d e%0d", s, ev),
              {tmr, rec, pop, msg}, {x[17], x[18], x[19], emsg});
        @(negedge clk); vld = 1'b0;
        check(state == 4'(x[11:8]) && err == !x[20], tag(s, ev),
              $sformatf("next s%0d e%0d", s, ev), {err, state}, {!x[20], 4'(x[11:8])});
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule